// File: doc/BRIEF.md
# Instruction Fetch and Next-PC Unit

This block is the fetch stage of a single-cycle processor core. It holds a 32-bit program counter, presents the instruction word stored at that address from a local instruction array, and picks the address for the next cycle. The next address is either the sequential one (PC plus four) or a PC-relative branch target.

Control supplies one branch bit. This bit means "this instruction is a conditional branch". The unit ANDs it with the ALU's zero flag to decide whether the branch is taken. A taken branch adds the sign-extended 16-bit immediate, shifted left by two, to the sequential address, not to the current PC.

The program counter has no enable and loads a new value on every clock edge. The instruction array is filled through a write port driven by a valid/ready pair. Ready is held high at all times, so a write offered with valid is always accepted at that clock edge and never back-pressured. Only the low address bits select a word; higher PC bits are ignored by the array.

Top module: `ifetch_npc`

## Requirements
- R1: A synchronous active-high `rst` makes `pc_q` equal 0 after the clock edge, and it overrides a taken branch offered in the same cycle.
- R2: `instr` is combinationally the array word at index `pc_q[AW+1:2]`, where AW = log2(IMEM_WORDS). It changes in the same cycle as `pc_q`, with no extra register.
- R3: With `br_sel` = 0, the next `pc_q` is `pc_q + 4`, whatever `alu_zero` and `imm16` are.
- R4: With `br_sel` = 1 and `alu_zero` = 1, the next `pc_q` is `pc_q + 4 + {sign-extended imm16, 2'b00}`.
- R5: With `br_sel` = 1 and `alu_zero` = 0, the next `pc_q` is `pc_q + 4`.
- R6: `imm16` is a two's complement value: when bit 15 is 1, the branch moves the PC backwards.
- R7: `pc_q` changes on every clock edge out of reset. There is no hold or enable.
- R8: `ld_ready` is always 1. When `ld_valid` = 1, `ld_data` is written to word `ld_addr` at the clock edge. A write to the word that the new PC selects is already visible on `instr` in the cycle after that edge.
- R9: PC arithmetic is modulo 2^32. A backward branch from 0 with `imm16` = 16'hFFFE gives 32'hFFFFFFFC, and the next sequential step gives 0.
- R10: `pc_q` bits above AW+1 do not take part in the array index. For example, PC 32'hFFFFFFFC reads word IMEM_WORDS-1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| br_sel | input | 1 | Instruction is a conditional branch |
| alu_zero | input | 1 | ALU result-is-zero flag |
| imm16 | input | 16 | Branch offset in words, two's complement |
| ld_valid | input | 1 | Instruction array write request |
| ld_ready | output | 1 | Write accepted (always 1) |
| ld_addr | input | AW | Word index to write |
| ld_data | input | 32 | Word to write |
| pc_q | output | 32 | Current program counter |
| instr | output | 32 | Instruction word at `pc_q` |

## Verification
Two pairs of events can fall in the same cycle. The first pair is a reset and a taken branch: the bench raises `rst` while `br_sel` and `alu_zero` are both 1 and expects PC 0 after the edge. The second pair is an array write and a taken branch: the bench writes a fresh word at the index of the branch target in the same cycle as the branch. It then expects the new word, not the old one, on `instr` in the next cycle. A reference model of the PC and of the array predicts every cycle's `pc_q` and `instr`.

// File: rtl/ifetch_pkg.sv
package ifetch_pkg;
  localparam int ADDR_W = 32;
  localparam int DATA_W = 32;
  localparam int IMM_W  = 16;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [DATA_W-1:0] word_t;

  typedef enum logic {
    NPC_SEQ    = 1'b0,
    NPC_BRANCH = 1'b1
  } npc_sel_e;

  localparam addr_t INSN_BYTES = addr_t'(4);

  // Word offset in bytes: sign-extend, then two zero bits below.
  function automatic addr_t word_offset(input logic [IMM_W-1:0] imm);
    return {{(ADDR_W-IMM_W-2){imm[IMM_W-1]}}, imm, 2'b00};
  endfunction
endpackage

// File: rtl/ifetch_imem.sv
module ifetch_imem
  import ifetch_pkg::*;
#(
  parameter int WORDS = 64,
  localparam int AW = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_idx,
  input  word_t         wr_data,
  input  logic [AW-1:0] rd_idx,
  output word_t         rd_data
);
  word_t mem [WORDS];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
  end

  assign rd_data = mem[rd_idx];

  // R8
  imem_write_lands_chk: assert property (@(posedge clk)
    wr_en |=> mem[$past(wr_idx)] == $past(wr_data));
endmodule

// File: rtl/ifetch_npc_calc.sv
module ifetch_npc_calc
  import ifetch_pkg::*;
(
  input  addr_t            pc,
  input  logic             br_sel,
  input  logic             zero,
  input  logic [IMM_W-1:0] imm,
  output addr_t            seq_pc,
  output addr_t            next_pc
);
  npc_sel_e sel;
  addr_t    target;

  always_comb begin
    seq_pc = pc + INSN_BYTES;
    target = seq_pc + word_offset(imm);
    sel    = (br_sel && zero) ? NPC_BRANCH : NPC_SEQ;
    unique case (sel)
      NPC_BRANCH: next_pc = target;
      default:    next_pc = seq_pc;
    endcase
  end
endmodule

// File: rtl/ifetch_pc_reg.sv
module ifetch_pc_reg
  import ifetch_pkg::*;
#(
  parameter addr_t RESET_PC = '0
) (
  input  logic  clk,
  input  logic  rst,
  input  addr_t d,
  output addr_t q
);
  always_ff @(posedge clk) begin
    if (rst) q <= RESET_PC;
    else     q <= d;
  end

  // R1
  rst_pc_zero_chk: assert property (@(posedge clk)
    rst |=> q == RESET_PC);
endmodule

// File: rtl/ifetch_npc.sv
module ifetch_npc
  import ifetch_pkg::*;
#(
  parameter int IMEM_WORDS = 64,
  localparam int AW = $clog2(IMEM_WORDS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          br_sel,
  input  logic          alu_zero,
  input  logic [15:0]   imm16,
  input  logic          ld_valid,
  output logic          ld_ready,
  input  logic [AW-1:0] ld_addr,
  input  logic [31:0]   ld_data,
  output logic [31:0]   pc_q,
  output logic [31:0]   instr
);
  addr_t seq_pc;
  addr_t next_pc;

  assign ld_ready = 1'b1;

  ifetch_npc_calc u_calc (
    .pc      (pc_q),
    .br_sel  (br_sel),
    .zero    (alu_zero),
    .imm     (imm16),
    .seq_pc  (seq_pc),
    .next_pc (next_pc)
  );

  ifetch_pc_reg #(.RESET_PC('0)) u_pc (
    .clk (clk),
    .rst (rst),
    .d   (next_pc),
    .q   (pc_q)
  );

  ifetch_imem #(.WORDS(IMEM_WORDS)) u_imem (
    .clk     (clk),
    .wr_en   (ld_valid),
    .wr_idx  (ld_addr),
    .wr_data (ld_data),
    .rd_idx  (pc_q[AW+1:2]),
    .rd_data (instr)
  );

  // R3 R5
  seq_step_chk: assert property (@(posedge clk) disable iff (rst)
    !(br_sel && alu_zero) |=> pc_q == $past(pc_q) + 32'd4);

  // R4 R6
  taken_step_chk: assert property (@(posedge clk) disable iff (rst)
    (br_sel && alu_zero) |=> pc_q == $past(pc_q) + 32'd4
      + {{14{$past(imm16[15])}}, $past(imm16), 2'b00});

  // R7
  pc_aligned_chk: assert property (@(posedge clk) disable iff (rst)
    pc_q[1:0] == 2'b00);

  // R8
  ld_ready_high_chk: assert property (@(posedge clk) ld_ready);
endmodule

// File: tb/ifetch_npc_tb_top.sv
`timescale 1ns/1ps
module ifetch_npc_tb_top;
  localparam int WORDS = 64;
  localparam int AW = $clog2(WORDS);

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          br_sel = 1'b0;
  logic          alu_zero = 1'b0;
  logic [15:0]   imm16 = '0;
  logic          ld_valid = 1'b0;
  logic          ld_ready;
  logic [AW-1:0] ld_addr = '0;
  logic [31:0]   ld_data = '0;
  logic [31:0]   pc_q;
  logic [31:0]   instr;

  always #2 clk = ~clk;

  ifetch_npc #(.IMEM_WORDS(WORDS)) dut_i (
    .clk(clk), .rst(rst), .br_sel(br_sel), .alu_zero(alu_zero),
    .imm16(imm16), .ld_valid(ld_valid), .ld_ready(ld_ready),
    .ld_addr(ld_addr), .ld_data(ld_data), .pc_q(pc_q), .instr(instr)
  );

  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;
  bit done = 0;

  logic [31:0] exp_pc_q [$];
  logic [31:0] exp_in_q [$];
  string       tag_q    [$];

  logic [31:0] m_mem [WORDS];
  logic [31:0] m_pc = '0;

  function automatic logic [31:0] pattern(input int i);
    return 32'hC3000000 ^ (32'(i) * 32'h00010203) ^ 32'(i);
  endfunction

  task automatic report;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  // Driver: set inputs at negedge, model the next edge, push expectation.
  task automatic step(input bit r, input bit b, input bit z,
                      input logic [15:0] imm, input bit lv,
                      input logic [AW-1:0] la, input logic [31:0] ld,
                      input string tag);
    @(negedge clk);
    rst = r; br_sel = b; alu_zero = z; imm16 = imm;
    ld_valid = lv; ld_addr = la; ld_data = ld;
    if (lv) m_mem[la] = ld;
    if (r) m_pc = '0;
    else if (b && z) m_pc = m_pc + 32'd4 + {{14{imm[15]}}, imm, 2'b00};
    else m_pc = m_pc + 32'd4;
    exp_pc_q.push_back(m_pc);
    exp_in_q.push_back(m_mem[m_pc[AW+1:2]]);
    tag_q.push_back(tag);
  endtask

  // Monitor: sample one time unit after each rising edge.
  always @(posedge clk) begin
    #1;
    if (exp_pc_q.size() > 0) begin
      logic [31:0] ep, ei;
      string t;
      ep = exp_pc_q.pop_front();
      ei = exp_in_q.pop_front();
      t  = tag_q.pop_front();
      n_cmp++;
      if (pc_q !== ep) begin
        n_bad++;
        $display("FAIL %s pc: actual %h expected %h", t, pc_q, ep);
      end
      n_cmp++;
      if (instr !== ei) begin
        n_bad++;
        $display("FAIL R2 instr (%s): actual %h expected %h", t, instr, ei);
      end
    end
  end

  // Watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000 && !done) begin
      n_bad++;
      $display("FAIL watchdog: actual %0d cycles expected under 5000", cycles);
      report();
    end
  end

  initial begin
    // Preload while in reset (R8 write path).
    for (int i = 0; i < WORDS; i++) begin
      @(negedge clk);
      rst = 1'b1; ld_valid = 1'b1; ld_addr = AW'(i); ld_data = pattern(i);
      m_mem[i] = pattern(i);
    end
    @(negedge clk);
    ld_valid = 1'b0;
    @(negedge clk);
    // R1 reset state
    n_cmp++;
    if (pc_q !== 32'h0) begin
      n_bad++;
      $display("FAIL R1 reset pc: actual %h expected %h", pc_q, 32'h0);
    end
    // R8 ready
    n_cmp++;
    if (ld_ready !== 1'b1) begin
      n_bad++;
      $display("FAIL R8 ld_ready: actual %b expected 1", ld_ready);
    end
    m_pc = '0;

    // R3 / R7: sequential steps with zero and immediate ignored
    step(0, 0, 1, 16'h7FFF, 0, '0, '0, "R3");
    step(0, 0, 0, 16'h8000, 0, '0, '0, "R3");
    step(0, 0, 1, 16'h0011, 0, '0, '0, "R7");
    step(0, 0, 1, 16'h0011, 0, '0, '0, "R7");
    // R5: branch not taken
    step(0, 1, 0, 16'h0005, 0, '0, '0, "R5");
    // R4: forward taken branch
    step(0, 1, 1, 16'h0003, 0, '0, '0, "R4");
    step(0, 0, 0, 16'h0000, 0, '0, '0, "R3");
    // R6: backward taken branch
    step(0, 1, 1, 16'hFFFE, 0, '0, '0, "R6");
    step(0, 1, 1, 16'hFFF0, 0, '0, '0, "R6");
    // R1: reset collides with taken branch
    step(1, 1, 1, 16'h0040, 0, '0, '0, "R1");
    // R9 / R10: wrap below zero, then back to zero
    step(0, 1, 1, 16'hFFFE, 0, '0, '0, "R9");
    step(0, 0, 0, 16'h0000, 0, '0, '0, "R9");
    // R10: branch past the array size, index wraps
    step(0, 1, 1, 16'h0041, 0, '0, '0, "R10");
    // R8: write lands at target of a taken branch in the same cycle
    begin
      logic [31:0] tgt;
      tgt = m_pc + 32'd4 + 32'd8;
      step(0, 1, 1, 16'h0002, 1, tgt[AW+1:2], 32'hDEADBEEF, "R8");
    end
    step(0, 0, 0, 16'h0000, 1, 6'd5, 32'h12345678, "R8");
    step(0, 0, 0, 16'h0000, 0, '0, '0, "R7");
    // R4 with largest positive offset
    step(0, 1, 1, 16'h7FFF, 0, '0, '0, "R4");
    step(0, 1, 0, 16'h8000, 0, '0, '0, "R5");

    @(negedge clk);
    @(negedge clk);
    done = 1;
    report();
  end
endmodule